// File: doc/BRIEF.md
# Two-Channel Serial Controller Register Interface

This block presents the processor-side register set of a two-channel serial communications controller. A processor reaches it through four I/O port addresses. Each channel has a data port and a control port. Control writes go through an indirect register pointer. The block keeps a bank of write registers for each channel. It answers control reads with a status byte and supplies a stored vector byte during an interrupt acknowledge cycle.

No serial line is driven here. Transmitted characters leave through a valid/ready byte stream for each channel. Received characters arrive through another valid/ready byte stream. Each direction has a small queue. The interrupt request is raised when a channel holds a received character and that channel has receive interrupts enabled.

A typical driver does three things. It resets each channel and loads the framing, interrupt and vector registers as pointer/value pairs. It then polls the status byte before each transmit write. It reads the data port from its interrupt handler.

Top module: `sercc_regfile`

## Requirements
- R1: `io_addr[0]` selects the channel (0 = A, 1 = B) and `io_addr[1]` selects the control port (1) or the data port (0). All higher address bits are ignored.
- R2: A control write with the pointer at 0 loads register 0, and its bits [2:0] become the pointer. The next control write loads the register the pointer names and returns the pointer to 0. A control read with a nonzero pointer returns 0x00 and clears the pointer.
- R3: A register-0 write whose bits [5:3] equal 3 (for example 0x18) resets the channel. The reset empties both queues of that channel, so no receive status remains pending, and sets its pointer to 0.
- R4: Register 2 of channel B holds the vector byte. While `inta` is high, `io_rdata` shows that byte and the bus access has no other effect. Register 2 of channel A does not change the vector.
- R5: `irq` is high exactly when some channel has a received byte queued and bits [4:3] of that channel's register 1 are nonzero (0x18 enables the interrupt). It rises one cycle after the byte is accepted and falls after the byte is read or the channel is reset.
- R6: A control read with the pointer at 0 returns the status byte. Bit 0 is set when a received byte is queued, bit 2 is set when the transmit queue is empty, and all other bits are 0.
- R7: A data write appends the byte to that channel's transmit queue. A data read returns the oldest received byte and removes it. Status bit 0 stays set while further bytes remain queued. A data read of an empty queue returns 0x00.
- R8: Values written to registers 3 and 4, such as 0xE1 and 0xC4, are stored but do not alter the bytes carried in either direction.
- R9: After reset every register and pointer is zero, both queues are empty (status 0x04), `irq` is low and `tx_valid` is low.
- R10: `tx_valid[i]` is high while channel i has a queued transmit byte, and that byte is held until `tx_ready[i]` is high. `rx_ready[i]` goes low when the receive queue is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_req | input | 1 | One-cycle bus access strobe |
| io_wr | input | 1 | 1 = write access, 0 = read access |
| io_addr | input | ADDR_W | Port address |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data or vector (combinational) |
| inta | input | 1 | Interrupt acknowledge cycle |
| irq | output | 1 | Interrupt request, active high |
| tx_valid | output | 2 | Transmit byte available, one bit per channel |
| tx_data | output | 16 | Transmit bytes; channel B in bits [15:8] |
| tx_ready | input | 2 | Transmit consumer accepts byte |
| rx_valid | input | 2 | Received byte offered |
| rx_data | input | 16 | Received bytes; channel B in bits [15:8] |
| rx_ready | output | 2 | Receive queue can accept a byte |

## Verification
The assertions rely on three conditions. `inta` and a bus access do not occur together in a way that matters, `io_req` is a single-cycle strobe, and transmit data pushed into a full queue is simply lost. Under those conditions, a queued transmit byte held against a low `tx_ready` stays unchanged unless the channel is reset. The stimulus drives every input on the falling clock edge and gives each access one active cycle and one idle cycle. It asserts `inta` only with `io_req` low and never pushes more transmit bytes than the queue holds.

// File: rtl/sercc_pkg.sv
package sercc_pkg;
    localparam int BYTE_W   = 8;
    localparam int NUM_CH   = 2;
    localparam int NUM_REG  = 8;
    localparam int PTR_W    = $clog2(NUM_REG);

    localparam int REG_CMD  = 0;
    localparam int REG_INT  = 1;
    localparam int REG_VEC  = 2;

    localparam logic [2:0] CMD_CHAN_RESET = 3'd3;

    localparam int ST_RX_AVAIL = 0;
    localparam int ST_TX_EMPTY = 2;

    typedef struct packed {
        logic wr_ctrl;
        logic rd_ctrl;
        logic wr_data;
        logic rd_data;
    } access_t;
endpackage

// File: rtl/sercc_byte_fifo.sv
module sercc_byte_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CAP  = CNT_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [IDX_W-1:0]        wptr;
        logic [IDX_W-1:0]        rptr;
        logic [CNT_W-1:0]        count;
    } fifo_state_t;

    fifo_state_t st_q, st_d;
    logic do_push, do_pop;

    assign empty = (st_q.count == '0);
    assign full  = (st_q.count == CAP);
    assign head  = st_q.mem[st_q.rptr];

    always_comb begin
        st_d    = st_q;
        do_push = push && !full;
        do_pop  = pop && !empty;
        if (flush) begin
            st_d.wptr  = '0;
            st_d.rptr  = '0;
            st_d.count = '0;
        end else begin
            if (do_push) begin
                st_d.mem[st_q.wptr] = push_data;
                st_d.wptr = (st_q.wptr == LAST) ? '0 : st_q.wptr + 1'b1;
            end
            if (do_pop) begin
                st_d.rptr = (st_q.rptr == LAST) ? '0 : st_q.rptr + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   st_d.count = st_q.count + 1'b1;
                2'b01:   st_d.count = st_q.count - 1'b1;
                default: st_d.count = st_q.count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/sercc_channel.sv
module sercc_channel
    import sercc_pkg::*;
#(
    parameter int RX_DEPTH = 4,
    parameter int TX_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  access_t           acc,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] ctrl_rdata,
    output logic [BYTE_W-1:0] data_rdata,
    output logic [BYTE_W-1:0] vec_byte,
    output logic              rx_int_en,
    output logic              rx_avail,
    output logic              chan_reset,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    input  logic              tx_ready,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    output logic              rx_ready
);
    typedef struct packed {
        logic [PTR_W-1:0]                ptr;
        logic [NUM_REG-1:0][BYTE_W-1:0]  regs;
    } chan_state_t;

    chan_state_t st_q, st_d;

    logic tx_empty, tx_full, rx_empty, rx_full;
    logic [BYTE_W-1:0] rx_head;
    logic [BYTE_W-1:0] status;
    logic unused_tx_full;

    assign unused_tx_full = tx_full;

    assign chan_reset = acc.wr_ctrl && (st_q.ptr == '0) &&
                        (wdata[5:3] == CMD_CHAN_RESET);

    always_comb begin
        status = '0;
        status[ST_RX_AVAIL] = !rx_empty;
        status[ST_TX_EMPTY] = tx_empty;
    end

    assign ctrl_rdata = (st_q.ptr == '0) ? status : '0;
    assign data_rdata = rx_empty ? '0 : rx_head;
    assign vec_byte   = st_q.regs[REG_VEC];
    assign rx_int_en  = |st_q.regs[REG_INT][4:3];
    assign rx_avail   = !rx_empty;
    assign tx_valid   = !tx_empty;
    assign rx_ready   = !rx_full;

    always_comb begin
        st_d = st_q;
        if (acc.wr_ctrl) begin
            if (st_q.ptr == '0) begin
                st_d.regs[REG_CMD] = wdata;
                st_d.ptr = chan_reset ? '0 : wdata[PTR_W-1:0];
            end else begin
                st_d.regs[st_q.ptr] = wdata;
                st_d.ptr = '0;
            end
        end else if (acc.rd_ctrl) begin
            st_d.ptr = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    sercc_byte_fifo #(.DEPTH(TX_DEPTH), .W(BYTE_W)) u_txq (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (chan_reset),
        .push      (acc.wr_data),
        .push_data (wdata),
        .pop       (tx_ready),
        .head      (tx_data),
        .empty     (tx_empty),
        .full      (tx_full)
    );

    sercc_byte_fifo #(.DEPTH(RX_DEPTH), .W(BYTE_W)) u_rxq (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (chan_reset),
        .push      (rx_valid),
        .push_data (rx_data),
        .pop       (acc.rd_data),
        .head      (rx_head),
        .empty     (rx_empty),
        .full      (rx_full)
    );
endmodule

// File: rtl/sercc_regfile.sv
module sercc_regfile
    import sercc_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int RX_DEPTH = 4,
    parameter int TX_DEPTH = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     io_req,
    input  logic                     io_wr,
    input  logic [ADDR_W-1:0]        io_addr,
    input  logic [BYTE_W-1:0]        io_wdata,
    output logic [BYTE_W-1:0]        io_rdata,
    input  logic                     inta,
    output logic                     irq,
    output logic [NUM_CH-1:0]        tx_valid,
    output logic [NUM_CH*BYTE_W-1:0] tx_data,
    input  logic [NUM_CH-1:0]        tx_ready,
    input  logic [NUM_CH-1:0]        rx_valid,
    input  logic [NUM_CH*BYTE_W-1:0] rx_data,
    output logic [NUM_CH-1:0]        rx_ready
);
    localparam int VEC_CH = 1;

    logic                         sel_ch;
    logic                         sel_ctrl;
    logic                         bus_live;
    logic unused_addr_hi;
    access_t                      acc      [NUM_CH];
    logic [NUM_CH-1:0][BYTE_W-1:0] ctrl_rd;
    logic [NUM_CH-1:0][BYTE_W-1:0] data_rd;
    logic [NUM_CH-1:0][BYTE_W-1:0] vec_b;
    logic [NUM_CH-1:0]            rx_en;
    logic [NUM_CH-1:0]            rx_avail;
    logic [NUM_CH-1:0]            ch_reset;

    assign sel_ch         = io_addr[0];
    assign sel_ctrl       = io_addr[1];
    assign bus_live       = io_req && !inta;
    assign unused_addr_hi = ^io_addr[ADDR_W-1:2];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic hit;
        assign hit = bus_live && (sel_ch == c[0]);
        always_comb begin
            acc[c].wr_ctrl = hit &&  io_wr &&  sel_ctrl;
            acc[c].rd_ctrl = hit && !io_wr &&  sel_ctrl;
            acc[c].wr_data = hit &&  io_wr && !sel_ctrl;
            acc[c].rd_data = hit && !io_wr && !sel_ctrl;
        end

        sercc_channel #(.RX_DEPTH(RX_DEPTH), .TX_DEPTH(TX_DEPTH)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .acc        (acc[c]),
            .wdata      (io_wdata),
            .ctrl_rdata (ctrl_rd[c]),
            .data_rdata (data_rd[c]),
            .vec_byte   (vec_b[c]),
            .rx_int_en  (rx_en[c]),
            .rx_avail   (rx_avail[c]),
            .chan_reset (ch_reset[c]),
            .tx_valid   (tx_valid[c]),
            .tx_data    (tx_data[c*BYTE_W +: BYTE_W]),
            .tx_ready   (tx_ready[c]),
            .rx_valid   (rx_valid[c]),
            .rx_data    (rx_data[c*BYTE_W +: BYTE_W]),
            .rx_ready   (rx_ready[c])
        );
    end

    always_comb begin
        if (inta)
            io_rdata = vec_b[VEC_CH];
        else if (io_req && !io_wr)
            io_rdata = sel_ctrl ? ctrl_rd[sel_ch] : data_rd[sel_ch];
        else
            io_rdata = '0;
    end

    assign irq = |(rx_avail & rx_en);
endmodule

// File: rtl/sercc_regfile_chk.sv
module sercc_regfile_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        io_req,
    input logic        io_wr,
    input logic [1:0]  io_addr,
    input logic        inta,
    input logic [7:0]  io_rdata,
    input logic        irq,
    input logic [1:0]  tx_valid,
    input logic [15:0] tx_data,
    input logic [1:0]  tx_ready,
    input logic [1:0]  rx_valid,
    input logic [1:0]  rx_ready,
    input logic [1:0]  rx_avail,
    input logic [1:0]  ch_reset
);
    assert_irq_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(|(rx_valid & rx_ready)) || $past(io_req && io_wr)));

    assert_irq_needs_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|rx_avail));

    assert_status_shape_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (io_req && !io_wr && !inta && io_addr[1]) |-> (io_rdata[7:3] == 5'd0 && io_rdata[1] == 1'b0));

    for (genvar i = 0; i < 2; i++) begin : g_chk
        assert_tx_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (tx_valid[i] && !tx_ready[i] && !ch_reset[i]) |=>
            (tx_valid[i] && $stable(tx_data[i*8 +: 8])));

        assert_reset_flush_R3: assert property (@(posedge clk) disable iff (!rst_n)
            ch_reset[i] |=> (!tx_valid[i] && rx_ready[i] && !rx_avail[i]));

        assert_data_push_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (io_req && io_wr && !inta && io_addr == {1'b0, i[0]}) |=> tx_valid[i]);
    end
endmodule

bind sercc_regfile sercc_regfile_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_req   (io_req),
    .io_wr    (io_wr),
    .io_addr  (io_addr[1:0]),
    .inta     (inta),
    .io_rdata (io_rdata),
    .irq      (irq),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .tx_ready (tx_ready),
    .rx_valid (rx_valid),
    .rx_ready (rx_ready),
    .rx_avail (rx_avail),
    .ch_reset (ch_reset)
);

// File: tb/sercc_regfile_test.sv
module sercc_regfile_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_req = 1'b0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        inta = 1'b0;
    logic        irq;
    logic [1:0]  tx_valid;
    logic [15:0] tx_data;
    logic [1:0]  tx_ready = '0;
    logic [1:0]  rx_valid = '0;
    logic [15:0] rx_data = '0;
    logic [1:0]  rx_ready;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    sercc_regfile uut (
        .clk(clk), .rst_n(rst_n), .io_req(io_req), .io_wr(io_wr),
        .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .inta(inta), .irq(irq), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_ready(rx_ready)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        io_req = 1'b1; io_wr = 1'b1; io_addr = a; io_wdata = d;
        @(negedge clk);
        io_req = 1'b0; io_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        io_req = 1'b1; io_wr = 1'b0; io_addr = a;
        #2 d = io_rdata;
        @(negedge clk);
        io_req = 1'b0;
    endtask

    task automatic rx_send(input int ch, input logic [7:0] d);
        @(negedge clk);
        rx_valid[ch] = 1'b1; rx_data[ch*8 +: 8] = d;
        @(negedge clk);
        rx_valid[ch] = 1'b0;
    endtask

    task automatic test_reset_state();
        logic [7:0] r;
        check("R9 irq", {15'd0, irq}, 16'd0);
        check("R9 tx_valid", {14'd0, tx_valid}, 16'd0);
        bus_read(8'h02, r); check("R9 status A", {8'd0, r}, 16'h0004);
        bus_read(8'h03, r); check("R9 status B", {8'd0, r}, 16'h0004);
    endtask

    task automatic test_decode();
        logic [7:0] r;
        bus_write(8'h00, 8'h55);
        check("R1 A data -> tx A", {14'd0, tx_valid}, 16'd1);
        check("R7 tx A byte", {8'd0, tx_data[7:0]}, 16'h0055);
        bus_write(8'hF5, 8'h66);
        check("R1 high bits ignored, B data", {14'd0, tx_valid}, 16'd3);
        check("R7 tx B byte", {8'd0, tx_data[15:8]}, 16'h0066);
        bus_read(8'h06, r); check("R6 status A tx busy", {8'd0, r}, 16'h0000);
        @(negedge clk); #1;
        check("R10 tx A held", {8'd0, tx_data[7:0]}, 16'h0055);
        tx_ready = 2'b11;
        @(negedge clk);
        tx_ready = 2'b00;
        check("R10 tx drained", {14'd0, tx_valid}, 16'd0);
        bus_read(8'h02, r); check("R6 status A tx empty", {8'd0, r}, 16'h0004);
    endtask

    task automatic test_pointer_irq();
        logic [7:0] r;
        rx_send(0, 8'h41);
        check("R5 no irq when disabled", {15'd0, irq}, 16'd0);
        bus_write(8'h02, 8'h01);
        bus_write(8'h02, 8'h18);
        check("R2/R5 WR1 load enables irq", {15'd0, irq}, 16'd1);
        bus_read(8'h02, r); check("R2 pointer back at 0, status", {8'd0, r}, 16'h0005);
        bus_read(8'h00, r); check("R7 rx byte", {8'd0, r}, 16'h0041);
        check("R5 irq drops after read", {15'd0, irq}, 16'd0);
        bus_write(8'h02, 8'h05);
        bus_read(8'h02, r); check("R2 nonzero pointer read", {8'd0, r}, 16'h0000);
        bus_read(8'h02, r); check("R2 pointer cleared by read", {8'd0, r}, 16'h0004);
        bus_read(8'h00, r); check("R7 empty read", {8'd0, r}, 16'h0000);
    endtask

    task automatic test_vector();
        bus_write(8'h03, 8'h02);
        bus_write(8'h03, 8'h60);
        bus_write(8'h02, 8'h02);
        bus_write(8'h02, 8'h77);
        @(negedge clk);
        inta = 1'b1;
        #2 check("R4 vector from B", {8'd0, io_rdata}, 16'h0060);
        @(negedge clk);
        inta = 1'b0;
        check("R4 inta side effects", {14'd0, tx_valid}, 16'd0);
    endtask

    task automatic test_chan_reset();
        logic [7:0] r;
        bus_write(8'h03, 8'h01);
        bus_write(8'h03, 8'h18);
        rx_send(1, 8'h99);
        check("R5 irq from B", {15'd0, irq}, 16'd1);
        bus_write(8'h01, 8'h12);
        bus_write(8'h03, 8'h18);
        check("R3 irq cleared", {15'd0, irq}, 16'd0);
        check("R3 tx flushed", {14'd0, tx_valid}, 16'd0);
        bus_read(8'h03, r); check("R3 status after reset", {8'd0, r}, 16'h0004);
        rx_send(1, 8'h33);
        check("R3 WR1 kept after reset", {15'd0, irq}, 16'd1);
        bus_read(8'h01, r); check("R7 B rx byte", {8'd0, r}, 16'h0033);
    endtask

    task automatic test_framing_queue();
        logic [7:0] r;
        bus_write(8'h02, 8'h04); bus_write(8'h02, 8'hC4);
        bus_write(8'h02, 8'h03); bus_write(8'h02, 8'hE1);
        bus_write(8'h00, 8'h3C);
        check("R8 tx byte unchanged", {8'd0, tx_data[7:0]}, 16'h003C);
        tx_ready[0] = 1'b1; @(negedge clk); tx_ready[0] = 1'b0;
        for (int k = 0; k < 4; k++) rx_send(0, 8'hA0 + 8'(k));
        check("R10 rx_ready low when full", {15'd0, rx_ready[0]}, 16'd0);
        for (int k = 0; k < 3; k++) begin
            bus_read(8'h00, r); check("R8/R7 rx order", {8'd0, r}, {8'd0, 8'hA0 + 8'(k)});
        end
        bus_read(8'h02, r); check("R7 status bit0 still set", {8'd0, r}, 16'h0005);
        bus_read(8'h00, r); check("R7 last byte", {8'd0, r}, 16'h00A3);
        bus_read(8'h02, r); check("R7 status after drain", {8'd0, r}, 16'h0004);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset_state();
        test_decode();
        test_pointer_irq();
        test_vector();
        test_chan_reset();
        test_framing_queue();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end
endmodule